// File: doc/BRIEF.md
# Transceiver SPI Access Engine

This block is an SPI master that carries out register, frame-buffer and SRAM accesses on a packet radio transceiver. A caller hands over one request at a time on a valid/ready port. The request gives an access kind, a register number or SRAM address, a data byte, and a length. The engine then runs the whole serial transaction. It drives an active-low select, a serial clock that idles low, and serial data out. It samples serial data in, and reports the outcome with a one-cycle response strobe.

Frame payloads move through byte-wide streaming ports. A frame-buffer write pulls its payload bytes from the write stream. A frame-buffer read pushes the bytes it receives onto the read stream. For that read, the engine takes the frame length from the first byte the radio returns. It adds one trailing link-quality byte to that length, and limits the total to the maximum the caller supplied.

Top module: `trx_spi_engine`

## Requirements
- R1: After reset, spi_csn is 1, spi_sck is 0, req_ready is 1, and wr_ready, rd_valid and rsp_valid are 0.
- R2: Every byte is shifted most significant bit first. spi_mosi holds a bit for one full serial clock period of CLK_DIV system clocks, with the clock low for the first part of that period and high for the rest. spi_miso is sampled on the system clock edge that raises spi_sck.
- R3: spi_csn goes low when a request is accepted and stays low until the last byte of that request has been shifted. It then goes high exactly once. spi_sck never rises while spi_csn is high.
- R4: Kind 1 (register write) sends 0xC0 OR the 6-bit register number (req_addr[5:0]), then req_wdata: 2 bytes in all.
- R5: Kind 0 (register read) sends 0x80 OR the register number, then clocks one byte while sending 0x00. The byte received is returned on rsp_rdata.
- R6: Kind 3 (frame-buffer write) sends 0x60, then req_len, then req_len payload bytes taken in order from the write stream. A length of 0 sends only the first two bytes. rsp_count returns req_len.
- R7: Kind 2 (frame-buffer read) sends 0x20, then receives a length byte L while sending 0x00. It then receives min(L+1, req_len) bytes and delivers them in order on the read stream, and returns that count on rsp_count. A maximum of 0 ends the transaction after the length byte.
- R8: Kind 4 (SRAM read) sends 0x00 and then the address byte req_addr, and then receives one byte, which is returned on rsp_rdata. Kind 5 (SRAM write) sends 0x40, the address byte, then req_wdata.
- R9: req_ready is 0 from the cycle after acceptance until the transaction ends. Each accepted request produces exactly one single-cycle rsp_valid pulse.
- R10: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data stays unchanged. No further serial clocking happens until the byte is taken, and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and accepting a request |
| req_kind | input | 3 | Access kind: 0 reg read, 1 reg write, 2 buffer read, 3 buffer write, 4 SRAM read, 5 SRAM write |
| req_addr | input | 8 | Register number (bits 5:0) or SRAM address |
| req_wdata | input | 8 | Data byte for register or SRAM writes |
| req_len | input | 8 | Buffer write payload length, or buffer read maximum count |
| wr_valid | input | 1 | Write-stream byte offered |
| wr_ready | output | 1 | Engine takes the offered write-stream byte |
| wr_data | input | 8 | Write-stream byte |
| rd_valid | output | 1 | Read-stream byte offered |
| rd_ready | input | 1 | Caller takes the read-stream byte |
| rd_data | output | 8 | Read-stream byte |
| rsp_valid | output | 1 | One-cycle end-of-transaction strobe |
| rsp_rdata | output | 8 | Byte read by a register or SRAM read |
| rsp_count | output | 8 | Stream bytes moved by a buffer access |
| spi_csn | output | 1 | Active-low select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the radio |
| spi_miso | input | 1 | Serial data from the radio |

## Verification
Some properties are checked on every cycle. The serial clock stays quiet while select is high. Data out holds steady through each clock-high phase. The request port stays closed while select is asserted. The response strobe lasts one cycle. A stalled read-stream byte holds steady. A buffer-read count never exceeds the caller's maximum. Other behaviour only the bench scenarios can show, using a modelled radio: the exact byte sequences of each access kind across swept register numbers, addresses and lengths; the length-plus-one rule and its clipping at L=255 and at a maximum of zero; bit order; the serial clock period; and the in-order delivery of payload under stalls on both streams.

// File: rtl/trx_spi_pkg.sv
package trx_spi_pkg;

    typedef enum logic [2:0] {
        ACC_REG_RD  = 3'd0,
        ACC_REG_WR  = 3'd1,
        ACC_BUF_RD  = 3'd2,
        ACC_BUF_WR  = 3'd3,
        ACC_SRAM_RD = 3'd4,
        ACC_SRAM_WR = 3'd5
    } acc_kind_e;

    localparam logic [7:0] OP_REG_RD  = 8'h80;
    localparam logic [7:0] OP_REG_WR  = 8'hC0;
    localparam logic [7:0] OP_BUF_RD  = 8'h20;
    localparam logic [7:0] OP_BUF_WR  = 8'h60;
    localparam logic [7:0] OP_SRAM_RD = 8'h00;
    localparam logic [7:0] OP_SRAM_WR = 8'h40;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_VAL,
        S_RONE,
        S_WLEN,
        S_WGET,
        S_WPAY,
        S_RLEN,
        S_RDAT,
        S_RPUSH,
        S_END
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        acc_kind_e  kind;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [7:0] len;
        logic [7:0] left;
        logic [7:0] cnt;
        logic [7:0] rdata;
        logic [7:0] rbyte;
        logic       csn;
    } seq_regs_t;

endpackage

// File: rtl/trx_spi_cmd_enc.sv
module trx_spi_cmd_enc
    import trx_spi_pkg::*;
(
    input  logic [2:0] kind_i,
    input  logic [5:0] reg_num_i,
    output logic [7:0] cmd_o
);
    always_comb begin
        case (acc_kind_e'(kind_i))
            ACC_REG_WR:  cmd_o = OP_REG_WR | {2'b00, reg_num_i};
            ACC_BUF_RD:  cmd_o = OP_BUF_RD;
            ACC_BUF_WR:  cmd_o = OP_BUF_WR;
            ACC_SRAM_RD: cmd_o = OP_SRAM_RD;
            ACC_SRAM_WR: cmd_o = OP_SRAM_WR;
            default:     cmd_o = OP_REG_RD | {2'b00, reg_num_i};
        endcase
    end
endmodule

// File: rtl/trx_spi_len_clip.sv
module trx_spi_len_clip #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] frame_len_i,
    input  logic [BYTE_W-1:0] limit_i,
    output logic [BYTE_W-1:0] count_o
);
    localparam int EXT_W = BYTE_W + 1;

    logic [EXT_W-1:0] with_lqi;

    always_comb begin
        with_lqi = {1'b0, frame_len_i} + EXT_W'(1);
        if (with_lqi > {1'b0, limit_i}) count_o = limit_i;
        else                            count_o = with_lqi[BYTE_W-1:0];
    end
endmodule

// File: rtl/trx_spi_shifter.sv
module trx_spi_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);
    localparam int LO_CYC = CLK_DIV - CLK_DIV / 2;
    localparam int CNT_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] RISE_AT = CNT_W'(LO_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_AT = CNT_W'(CLK_DIV - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       bidx;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic             sck;
        logic             done;
    } shf_regs_t;

    shf_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.bidx = 3'd0;
                d.tx   = tx_i;
                d.sck  = 1'b0;
            end
        end else begin
            if (q.cnt == RISE_AT) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[6:0], miso_i};
            end
            if (q.cnt == LAST_AT) begin
                d.cnt = '0;
                d.sck = 1'b0;
                if (q.bidx == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bidx = q.bidx + 3'd1;
                    d.tx   = {q.tx[6:0], 1'b0};
                end
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck_o  = q.sck;
    assign mosi_o = q.tx[7];
    assign done_o = q.done;
    assign rx_o   = q.rx;

    // R2: data out never moves while the serial clock is high
    assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> $stable(mosi_o));

    // R2: the clock is low whenever no byte is in flight
    assert_sck_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !sck_o);
endmodule

// File: rtl/trx_spi_engine.sv
module trx_spi_engine
    import trx_spi_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [2:0] req_kind,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    input  logic [7:0] req_len,
    input  logic       wr_valid,
    output logic       wr_ready,
    input  logic [7:0] wr_data,
    output logic       rd_valid,
    input  logic       rd_ready,
    output logic [7:0] rd_data,
    output logic       rsp_valid,
    output logic [7:0] rsp_rdata,
    output logic [7:0] rsp_count,
    output logic       spi_csn,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    seq_regs_t  q, d;
    logic       sh_start;
    logic [7:0] sh_tx;
    logic       sh_done;
    logic [7:0] sh_rx;
    logic [7:0] cmd_byte;
    logic [7:0] clip_cnt;

    trx_spi_cmd_enc u_enc (
        .kind_i    (req_kind),
        .reg_num_i (req_addr[5:0]),
        .cmd_o     (cmd_byte)
    );

    trx_spi_len_clip #(.BYTE_W(8)) u_clip (
        .frame_len_i (sh_rx),
        .limit_i     (q.len),
        .count_o     (clip_cnt)
    );

    trx_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .tx_i    (sh_tx),
        .miso_i  (spi_miso),
        .sck_o   (spi_sck),
        .mosi_o  (spi_mosi),
        .done_o  (sh_done),
        .rx_o    (sh_rx)
    );

    always_comb begin
        d        = q;
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.kind   = acc_kind_e'(req_kind);
                    d.addr   = req_addr;
                    d.wdata  = req_wdata;
                    d.len    = req_len;
                    d.cnt    = 8'd0;
                    d.rdata  = 8'd0;
                    d.csn    = 1'b0;
                    sh_start = 1'b1;
                    sh_tx    = cmd_byte;
                    d.st     = S_CMD;
                end
            end
            S_CMD: begin
                if (sh_done) begin
                    sh_start = 1'b1;
                    case (q.kind)
                        ACC_REG_WR: begin
                            sh_tx = q.wdata;
                            d.st  = S_VAL;
                        end
                        ACC_BUF_WR: begin
                            sh_tx = q.len;
                            d.st  = S_WLEN;
                        end
                        ACC_BUF_RD: begin
                            d.st = S_RLEN;
                        end
                        ACC_SRAM_RD, ACC_SRAM_WR: begin
                            sh_tx = q.addr;
                            d.st  = S_ADDR;
                        end
                        default: begin
                            d.st = S_RONE;
                        end
                    endcase
                end
            end
            S_ADDR: begin
                if (sh_done) begin
                    sh_start = 1'b1;
                    if (q.kind == ACC_SRAM_WR) begin
                        sh_tx = q.wdata;
                        d.st  = S_VAL;
                    end else begin
                        d.st = S_RONE;
                    end
                end
            end
            S_VAL: begin
                if (sh_done) begin
                    d.csn = 1'b1;
                    d.st  = S_END;
                end
            end
            S_RONE: begin
                if (sh_done) begin
                    d.rdata = sh_rx;
                    d.csn   = 1'b1;
                    d.st    = S_END;
                end
            end
            S_WLEN: begin
                if (sh_done) begin
                    if (q.len == 8'd0) begin
                        d.csn = 1'b1;
                        d.st  = S_END;
                    end else begin
                        d.left = q.len;
                        d.st   = S_WGET;
                    end
                end
            end
            S_WGET: begin
                if (wr_valid) begin
                    sh_start = 1'b1;
                    sh_tx    = wr_data;
                    d.left   = q.left - 8'd1;
                    d.cnt    = q.cnt + 8'd1;
                    d.st     = S_WPAY;
                end
            end
            S_WPAY: begin
                if (sh_done) begin
                    if (q.left == 8'd0) begin
                        d.csn = 1'b1;
                        d.st  = S_END;
                    end else begin
                        d.st = S_WGET;
                    end
                end
            end
            S_RLEN: begin
                if (sh_done) begin
                    if (clip_cnt == 8'd0) begin
                        d.csn = 1'b1;
                        d.st  = S_END;
                    end else begin
                        d.left   = clip_cnt;
                        d.cnt    = clip_cnt;
                        sh_start = 1'b1;
                        d.st     = S_RDAT;
                    end
                end
            end
            S_RDAT: begin
                if (sh_done) begin
                    d.rbyte = sh_rx;
                    d.st    = S_RPUSH;
                end
            end
            S_RPUSH: begin
                if (rd_ready) begin
                    d.left = q.left - 8'd1;
                    if (q.left == 8'd1) begin
                        d.csn = 1'b1;
                        d.st  = S_END;
                    end else begin
                        sh_start = 1'b1;
                        d.st     = S_RDAT;
                    end
                end
            end
            S_END: begin
                d.st = S_IDLE;
            end
            default: begin
                d.csn = 1'b1;
                d.st  = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= S_IDLE;
            q.csn <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == S_IDLE);
    assign wr_ready  = (q.st == S_WGET);
    assign rd_valid  = (q.st == S_RPUSH);
    assign rd_data   = q.rbyte;
    assign rsp_valid = (q.st == S_END);
    assign rsp_rdata = q.rdata;
    assign rsp_count = q.cnt;
    assign spi_csn   = q.csn;

    // R3: no serial clocking outside a selected transaction
    assert_sck_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !spi_sck);

    // R9: no new request while the radio is selected
    assert_ready_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_csn |-> !req_ready);

    // R9: response strobe lasts exactly one cycle
    assert_rsp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: a stalled read byte is held
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R10: no serial clock pulse while a read byte waits
    assert_rd_noclk_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !spi_sck);

    // R7: delivered count never exceeds the caller's maximum
    assert_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && q.kind == ACC_BUF_RD) |-> (rsp_count <= q.len));
endmodule

// File: tb/sim_trx_spi_engine.sv
`timescale 1ns/1ps
module sim_trx_spi_engine;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_kind = 3'd0;
    logic [7:0] req_addr = 8'd0;
    logic [7:0] req_wdata = 8'd0;
    logic [7:0] req_len = 8'd0;
    logic       wr_valid = 1'b0;
    logic       wr_ready;
    logic [7:0] wr_data = 8'd0;
    logic       rd_valid;
    logic       rd_ready = 1'b0;
    logic [7:0] rd_data;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic [7:0] rsp_count;
    logic       spi_csn;
    logic       spi_sck;
    logic       spi_mosi;
    logic       spi_miso;

    trx_spi_engine #(.CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_count(rsp_count),
        .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int sl_bits = 0;
    int base = 0;
    int last_rise = 0;
    int per_bad = 0;
    int idle_bad = 0;
    int csn_rises = 0;
    int rsp_seen = 0;
    int wr_idx = 0;
    int wr_total = 0;
    int rd_n = 0;
    int rel = 0;
    logic [7:0] sh_in = 8'd0;
    logic [7:0] slave_tx [0:299];
    logic [7:0] mosi_log [0:299];
    logic [7:0] rd_log [0:299];
    logic [8:0] byte_ix;
    logic [2:0] bit_ix;
    logic [7:0] got_rdata;
    logic [7:0] got_cnt;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // radio model: shifts out slave_tx MSB first, logs what it receives
    assign byte_ix  = 9'((sl_bits - base) / 8);
    assign bit_ix   = 3'(7 - ((sl_bits - base) % 8));
    assign spi_miso = slave_tx[byte_ix][bit_ix];

    always @(posedge spi_sck) begin
        if (spi_csn) idle_bad++;
        rel = sl_bits - base;
        if ((rel % 8) != 0 && (cyc - last_rise) != DIV) per_bad++;
        last_rise = cyc;
        sh_in = {sh_in[6:0], spi_mosi};
        if ((rel % 8) == 7) mosi_log[9'(rel / 8)] = sh_in;
        sl_bits++;
    end

    always @(posedge spi_csn) csn_rises++;

    // stream driver and collector
    initial begin
        forever begin
            @(negedge clk);
            if (wr_valid && wr_ready) wr_idx++;
            if (rd_valid && rd_ready) begin
                rd_log[9'(rd_n)] = rd_data;
                rd_n++;
            end
            if (rsp_valid) rsp_seen++;
            @(posedge clk);
            #1;
            wr_valid = (wr_idx < wr_total) && ((cyc % 3) != 0);
            wr_data  = 8'(wr_idx * 37 + 5);
            rd_ready = ((cyc % 4) != 1);
        end
    end

    task automatic fill(input int seed);
        for (int i = 0; i < 300; i++) slave_tx[i] = 8'(i * 29 + seed);
    endtask

    task automatic run(input logic [2:0] k, input logic [7:0] a,
                       input logic [7:0] w, input logic [7:0] l);
        int rises0;
        int rsp0;
        base     = sl_bits;
        rd_n     = 0;
        wr_idx   = 0;
        wr_total = (k == 3'd3) ? int'(l) : 0;
        rises0   = csn_rises;
        rsp0     = rsp_seen;
        @(negedge clk);
        req_kind = k; req_addr = a; req_wdata = w; req_len = l;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!req_ready && !spi_csn, "R9 busy after accept", int'(req_ready), 0);
        while (!rsp_valid) @(negedge clk);
        got_rdata = rsp_rdata;
        got_cnt   = rsp_count;
        @(negedge clk);
        @(negedge clk);
        chk(csn_rises - rises0 == 1, "R3 select released once", csn_rises - rises0, 1);
        chk(rsp_seen - rsp0 == 1, "R9 one response pulse", rsp_seen - rsp0, 1);
    endtask

    task automatic chk_bytes(input int n, input string tag);
        chk(sl_bits - base == 8 * n, {tag, " bit count"}, sl_bits - base, 8 * n);
    endtask

    int exp_cnt;

    initial begin
        fill(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(spi_csn == 1'b1, "R1 csn", int'(spi_csn), 1);
        chk(spi_sck == 1'b0, "R1 sck", int'(spi_sck), 0);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(!rd_valid && !rsp_valid && !wr_ready, "R1 strobes",
            int'({rd_valid, rsp_valid, wr_ready}), 0);

        // R4 register write sweep
        for (int r = 0; r < 64; r++) begin
            run(3'd1, 8'(r), 8'(r * 5 + 3), 8'd0);
            chk_bytes(2, "R4");
            chk(mosi_log[0] == (8'hC0 | 8'(r)), "R4 cmd", int'(mosi_log[0]), int'(8'hC0 | 8'(r)));
            chk(mosi_log[1] == 8'(r * 5 + 3), "R4 value", int'(mosi_log[1]), int'(8'(r * 5 + 3)));
        end

        // R5 register read sweep (also R2 bit order on receive)
        for (int r = 0; r < 64; r++) begin
            fill(r * 13 + 7);
            run(3'd0, {2'b11, 6'(r)}, 8'h00, 8'd0);
            chk_bytes(2, "R5");
            chk(mosi_log[0] == (8'h80 | 8'(r)), "R5 cmd", int'(mosi_log[0]), int'(8'h80 | 8'(r)));
            chk(mosi_log[1] == 8'h00, "R5 filler", int'(mosi_log[1]), 0);
            chk(got_rdata == slave_tx[1], "R5 rdata", int'(got_rdata), int'(slave_tx[1]));
        end

        // R8 SRAM write and read
        for (int a = 0; a < 256; a += 17) begin
            run(3'd5, 8'(a), ~8'(a), 8'd0);
            chk_bytes(3, "R8 write");
            chk(mosi_log[0] == 8'h40, "R8 write cmd", int'(mosi_log[0]), 'h40);
            chk(mosi_log[1] == 8'(a), "R8 write addr", int'(mosi_log[1]), a);
            chk(mosi_log[2] == ~8'(a), "R8 write data", int'(mosi_log[2]), int'(~8'(a)));
            fill(a + 3);
            run(3'd4, 8'(a), 8'h00, 8'd0);
            chk_bytes(3, "R8 read");
            chk(mosi_log[0] == 8'h00, "R8 read cmd", int'(mosi_log[0]), 0);
            chk(mosi_log[1] == 8'(a), "R8 read addr", int'(mosi_log[1]), a);
            chk(got_rdata == slave_tx[2], "R8 read data", int'(got_rdata), int'(slave_tx[2]));
        end

        // R6 buffer write, including zero length
        for (int n = 0; n < 9; n++) begin
            int len;
            len = (n == 8) ? 40 : n;
            run(3'd3, 8'h00, 8'h00, 8'(len));
            chk_bytes(2 + len, "R6");
            chk(mosi_log[0] == 8'h60, "R6 cmd", int'(mosi_log[0]), 'h60);
            chk(mosi_log[1] == 8'(len), "R6 length", int'(mosi_log[1]), len);
            for (int i = 0; i < len; i++)
                chk(mosi_log[2 + i] == 8'(i * 37 + 5), "R6 payload",
                    int'(mosi_log[2 + i]), int'(8'(i * 37 + 5)));
            chk(int'(got_cnt) == len, "R6 count", int'(got_cnt), len);
        end

        // R7 buffer read: length+1 rule and clipping (R10 stalls via rd_ready)
        for (int li = 0; li < 4; li++) begin
            for (int mi = 0; mi < 5; mi++) begin
                int flen;
                int mx;
                flen = (li == 0) ? 0 : (li == 1) ? 2 : (li == 2) ? 5 : 255;
                mx   = (mi == 0) ? 0 : (mi == 1) ? 1 : (mi == 2) ? 3 : (mi == 3) ? 7 : 255;
                fill(li * 7 + mi);
                slave_tx[1] = 8'(flen);
                exp_cnt = (flen + 1 < mx) ? flen + 1 : mx;
                run(3'd2, 8'h00, 8'h00, 8'(mx));
                chk_bytes(2 + exp_cnt, "R7");
                chk(mosi_log[0] == 8'h20, "R7 cmd", int'(mosi_log[0]), 'h20);
                chk(int'(got_cnt) == exp_cnt, "R7 count", int'(got_cnt), exp_cnt);
                chk(rd_n == exp_cnt, "R10 stream bytes", rd_n, exp_cnt);
                for (int i = 0; i < exp_cnt; i++)
                    chk(rd_log[i] == slave_tx[2 + i], "R10 stream data",
                        int'(rd_log[i]), int'(slave_tx[2 + i]));
            end
        end

        chk(per_bad == 0, "R2 serial clock period", per_bad, 0);
        chk(idle_bad == 0, "R3 clock while deselected", idle_bad, 0);
        chk(spi_csn == 1'b1 && spi_sck == 1'b0, "R3 idle lines",
            int'({spi_csn, spi_sck}), 2);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog act=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule